// File: doc/BRIEF.md
# Virtual-Channel Packet Switch with Time-Shared Crossbar

This block routes packets from four input streams to four output ports of a tree-shaped data network. Every output port owns two virtual channels (VCs), each with its own small buffer and its own valid/ready pair toward the consumer. A packet opens with a header flit whose low bits give the destination port. It closes with an all-ones tail flit. The route taken is fixed by the header.

Every input queues its flits in a small FIFO. A coordinator binds each new packet to a free VC of its destination port and keeps that binding until the tail has crossed. A round-robin arbiter then lets one input per cycle move one flit over the shared crossbar lane. Each VC moves through four states: free (idle), receiving (busy), complete (ready) and drained (empty). After the consumer has taken the tail, it must pulse a per-VC acknowledge to return the VC to the free pool. A packet that finds no free VC waits at its own input and does not hold up the other inputs.

Top module: `tdm_vc_switch`

## Requirements
- R1: After reset, every input reports ready, no VC output is valid, and all eight VCs report free on `vc_idle`.
- R2: Header bits [1:0] select the destination port. The packet comes out on one VC of that port (VC index = 2*port + k, k in 0..1). Its flits arrive unchanged and in their original order, including the header and the 0xFF tail.
- R3: A header is bound to the lowest-indexed free VC of its port. From the cycle after the header crosses, that VC no longer reports free.
- R4: A VC returns to free only after its tail flit has been taken at the output and `vc_ack` has then been pulsed. A pulse on `vc_ack` while the VC still holds or expects flits has no effect.
- R5: Until its tail (a non-header flit equal to 0xFF) has crossed, a VC carries only flits from the input that owns it. Packets are never interleaved within one VC.
- R6: A header whose port has no free VC stalls at its input. Its input FIFO then fills and drops `in_ready`, while the other inputs keep delivering to other ports.
- R7: At most one flit crosses per cycle, and only from an input that requests. The grant goes round robin, and the search starts after the input granted last. After reset, input 0 is first in line.
- R8: While `out_ready` is low, a valid VC output keeps the same flit and stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 4 | Flit valid, one bit per input |
| in_data | input | 32 | Flit data, 8 bits per input (input i at bits 8i+7:8i) |
| in_ready | output | 4 | Input FIFO can accept a flit |
| out_valid | output | 8 | VC holds a flit for its consumer |
| out_data | output | 64 | Head flit of each VC, 8 bits per VC |
| out_ready | input | 8 | Consumer takes the head flit of the VC |
| vc_ack | input | 8 | Consumer releases a drained VC |
| vc_idle | output | 8 | VC is free for a new packet |

## Verification
The hardest situation to reach is a stall: a header has to find both VCs of its port taken while another input still flows. The bench sets this up by withholding `out_ready` on both VCs of one port, so that two packets stay parked there. A third packet aimed at that port then sits behind its full input FIFO, and meanwhile a fourth packet goes to a different port. Releasing one VC and acknowledging it must then let the stalled packet through on exactly that channel. A fresh reset with four simultaneous packets to distinct ports exposes the round-robin order as first-flit arrival times that are spaced one cycle apart.

// File: rtl/tdmsw_pkg.sv
package tdmsw_pkg;
  typedef enum logic [1:0] {
    VC_IDLE  = 2'd0,
    VC_BUSY  = 2'd1,
    VC_READY = 2'd2,
    VC_EMPTY = 2'd3
  } vc_state_e;
endpackage

// File: rtl/tdmsw_fifo.sv
module tdmsw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             do_push, do_pop;

  assign do_push = push && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    cnt_nx    = cnt_q;
    if (do_push) wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    if (do_push && !do_pop)      cnt_nx = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      cnt_q  <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  assign dout = mem[rd_ptr];
  assign cnt  = cnt_q;
endmodule

// File: rtl/tdmsw_vc_track.sv
module tdmsw_vc_track
  import tdmsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      alloc,
  input  logic      tail_in,
  input  logic      drain_last,
  input  logic      ack,
  output vc_state_e state
);
  vc_state_e st_q, st_nx;

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      VC_IDLE:  if (alloc)      st_nx = VC_BUSY;
      VC_BUSY:  if (tail_in)    st_nx = VC_READY;
      VC_READY: if (drain_last) st_nx = VC_EMPTY;
      VC_EMPTY: if (ack)        st_nx = VC_IDLE;
      default:                  st_nx = VC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= VC_IDLE;
    else        st_q <= st_nx;
  end

  assign state = st_q;
endmodule

// File: rtl/tdmsw_rr_arb.sv
module tdmsw_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] gidx
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] ptr_q, ptr_nx;

  always_comb begin
    int  idx;
    logic found;
    grant = '0;
    gidx  = ptr_q;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(ptr_q) + off) % N;
      if (!found && req[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        gidx       = IDX_W'(idx);
      end
    end
  end

  always_comb begin
    ptr_nx = ptr_q;
    if (|grant) ptr_nx = gidx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= IDX_W'(N - 1);
    else        ptr_q <= ptr_nx;
  end
endmodule

// File: rtl/tdmsw_coord.sv
module tdmsw_coord #(
  parameter int N_IN        = 4,
  parameter int N_PORT      = 4,
  parameter int VC_PER_PORT = 2,
  parameter int W           = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [N_IN-1:0]                            head_valid,
  input  logic [N_IN*W-1:0]                          head_data,
  input  logic [N_PORT*VC_PER_PORT-1:0]              vc_idle,
  input  logic [N_PORT*VC_PER_PORT-1:0]              vc_full,
  input  logic [N_IN-1:0]                            grant,
  input  logic [$clog2(N_IN)-1:0]                    gidx,
  output logic [N_IN-1:0]                            req,
  output logic                                       wr_en,
  output logic [$clog2(N_PORT*VC_PER_PORT)-1:0]      wr_vc,
  output logic                                       alloc_en,
  output logic                                       tail_en
);
  localparam int NVC    = N_PORT * VC_PER_PORT;
  localparam int VC_W   = $clog2(NVC);
  localparam int PORT_W = $clog2(N_PORT);
  localparam logic [W-1:0] TAIL_FLIT = {W{1'b1}};

  logic [N_IN-1:0]           bound_q, bound_nx;
  logic [N_IN-1:0][VC_W-1:0] bvc_q, bvc_nx;
  logic [N_IN-1:0][VC_W-1:0] tgt;
  logic [N_IN-1:0]           cand;
  logic [W-1:0]              g_flit;

  // Free-channel lookup per input: lowest free VC of the header's port.
  always_comb begin
    int dest;
    for (int i = 0; i < N_IN; i++) begin
      dest    = int'(head_data[i*W +: PORT_W]);
      cand[i] = 1'b0;
      tgt[i]  = bvc_q[i];
      if (!bound_q[i]) begin
        for (int k = VC_PER_PORT - 1; k >= 0; k--) begin
          if (vc_idle[dest*VC_PER_PORT + k]) begin
            cand[i] = 1'b1;
            tgt[i]  = VC_W'(dest*VC_PER_PORT + k);
          end
        end
      end
      req[i] = head_valid[i] && (bound_q[i] ? !vc_full[bvc_q[i]] : cand[i]);
    end
  end

  assign g_flit   = head_data[gidx*W +: W];
  assign wr_en    = |grant;
  assign wr_vc    = tgt[gidx];
  assign alloc_en = wr_en && !bound_q[gidx];
  assign tail_en  = wr_en && bound_q[gidx] && (g_flit == TAIL_FLIT);

  always_comb begin
    bound_nx = bound_q;
    bvc_nx   = bvc_q;
    if (alloc_en) begin
      bound_nx[gidx] = 1'b1;
      bvc_nx[gidx]   = tgt[gidx];
    end
    if (tail_en) bound_nx[gidx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q <= '0;
      bvc_q   <= '0;
    end else begin
      bound_q <= bound_nx;
      bvc_q   <= bvc_nx;
    end
  end
endmodule

// File: rtl/tdm_vc_switch.sv
module tdm_vc_switch
  import tdmsw_pkg::*;
#(
  parameter int N_IN        = 4,
  parameter int N_PORT      = 4,
  parameter int VC_PER_PORT = 2,
  parameter int FLIT_W      = 8,
  parameter int IN_DEPTH    = 2,
  parameter int VC_DEPTH    = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N_IN-1:0]                      in_valid,
  input  logic [N_IN*FLIT_W-1:0]               in_data,
  output logic [N_IN-1:0]                      in_ready,
  output logic [N_PORT*VC_PER_PORT-1:0]        out_valid,
  output logic [N_PORT*VC_PER_PORT*FLIT_W-1:0] out_data,
  input  logic [N_PORT*VC_PER_PORT-1:0]        out_ready,
  input  logic [N_PORT*VC_PER_PORT-1:0]        vc_ack,
  output logic [N_PORT*VC_PER_PORT-1:0]        vc_idle
);
  localparam int NVC     = N_PORT * VC_PER_PORT;
  localparam int VC_W    = $clog2(NVC);
  localparam int IN_W    = $clog2(N_IN);
  localparam int ICNT_W  = $clog2(IN_DEPTH + 1);
  localparam int VCNT_W  = $clog2(VC_DEPTH + 1);

  logic [1:0] rst_sync;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  logic [N_IN-1:0]        head_valid;
  logic [N_IN*FLIT_W-1:0] head_data;
  logic [N_IN-1:0]        req, grant;
  logic [IN_W-1:0]        gidx;
  logic                   wr_en, alloc_en, tail_en;
  logic [VC_W-1:0]        wr_vc;
  logic [FLIT_W-1:0]      xbar_flit;
  logic [NVC-1:0]         vc_full;

  // Input queues
  for (genvar i = 0; i < N_IN; i++) begin : g_in
    logic [ICNT_W-1:0] icnt;
    tdmsw_fifo #(.W(FLIT_W), .DEPTH(IN_DEPTH)) u_q (
      .clk  (clk),
      .rst_n(srst_n),
      .push (in_valid[i] && in_ready[i]),
      .din  (in_data[i*FLIT_W +: FLIT_W]),
      .pop  (grant[i]),
      .dout (head_data[i*FLIT_W +: FLIT_W]),
      .cnt  (icnt)
    );
    assign head_valid[i] = (icnt != '0);
    assign in_ready[i]   = srst_n && (icnt != ICNT_W'(IN_DEPTH));
  end

  tdmsw_rr_arb #(.N(N_IN)) u_arb (
    .clk  (clk),
    .rst_n(srst_n),
    .req  (req),
    .grant(grant),
    .gidx (gidx)
  );

  tdmsw_coord #(
    .N_IN(N_IN), .N_PORT(N_PORT), .VC_PER_PORT(VC_PER_PORT), .W(FLIT_W)
  ) u_coord (
    .clk       (clk),
    .rst_n     (srst_n),
    .head_valid(head_valid),
    .head_data (head_data),
    .vc_idle   (vc_idle),
    .vc_full   (vc_full),
    .grant     (grant),
    .gidx      (gidx),
    .req       (req),
    .wr_en     (wr_en),
    .wr_vc     (wr_vc),
    .alloc_en  (alloc_en),
    .tail_en   (tail_en)
  );

  // Time-shared crossbar lane: one granted input per cycle
  assign xbar_flit = head_data[gidx*FLIT_W +: FLIT_W];

  // Output virtual channels
  for (genvar v = 0; v < NVC; v++) begin : g_vc
    logic [VCNT_W-1:0] vcnt;
    logic              sel, pop;
    vc_state_e         st;

    assign sel = wr_en && (wr_vc == VC_W'(v));
    assign pop = out_ready[v] && (vcnt != '0);

    tdmsw_fifo #(.W(FLIT_W), .DEPTH(VC_DEPTH)) u_buf (
      .clk  (clk),
      .rst_n(srst_n),
      .push (sel),
      .din  (xbar_flit),
      .pop  (pop),
      .dout (out_data[v*FLIT_W +: FLIT_W]),
      .cnt  (vcnt)
    );

    tdmsw_vc_track u_trk (
      .clk       (clk),
      .rst_n     (srst_n),
      .alloc     (sel && alloc_en),
      .tail_in   (sel && tail_en),
      .drain_last(pop && (vcnt == VCNT_W'(1))),
      .ack       (vc_ack[v]),
      .state     (st)
    );

    assign out_valid[v] = (vcnt != '0);
    assign vc_full[v]   = (vcnt == VCNT_W'(VC_DEPTH));
    assign vc_idle[v]   = (st == VC_IDLE);
  end
endmodule

// File: rtl/tdmsw_checker.sv
module tdmsw_checker #(
  parameter int N_IN   = 4,
  parameter int NVC    = 8,
  parameter int FLIT_W = 8
) (
  input logic                    clk,
  input logic                    srst_n,
  input logic [N_IN-1:0]         req,
  input logic [N_IN-1:0]         grant,
  input logic [NVC-1:0]          out_valid,
  input logic [NVC*FLIT_W-1:0]   out_data,
  input logic [NVC-1:0]          out_ready,
  input logic [NVC-1:0]          vc_idle
);
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(grant));

  a_r7_grant_has_req: assert property (@(posedge clk) disable iff (!srst_n)
    (grant & ~req) == '0);

  for (genvar v = 0; v < NVC; v++) begin : g_v
    a_r3_free_vc_empty: assert property (@(posedge clk) disable iff (!srst_n)
      vc_idle[v] |-> !out_valid[v]);

    a_r4_no_early_free: assert property (@(posedge clk) disable iff (!srst_n)
      (!vc_idle[v] && out_valid[v]) |=> !vc_idle[v]);

    a_r8_hold_flit: assert property (@(posedge clk) disable iff (!srst_n)
      (out_valid[v] && !out_ready[v]) |=>
        (out_valid[v] && $stable(out_data[v*FLIT_W +: FLIT_W])));
  end
endmodule

bind tdm_vc_switch tdmsw_checker #(
  .N_IN(N_IN), .NVC(N_PORT*VC_PER_PORT), .FLIT_W(FLIT_W)
) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .req      (req),
  .grant    (grant),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_ready(out_ready),
  .vc_idle  (vc_idle)
);

// File: tb/tdm_vc_switch_bench.sv
module tdm_vc_switch_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  in_valid;
  logic [31:0] in_data;
  logic [3:0]  in_ready;
  logic [7:0]  out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_ready;
  logic [7:0]  vc_ack;
  logic [7:0]  vc_idle;

  logic       drv_v [4];
  logic [7:0] drv_d [4];

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      in_valid[i]       = drv_v[i];
      in_data[i*8 +: 8] = drv_d[i];
    end
  end

  tdm_vc_switch u_tdm_vc_switch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .vc_ack(vc_ack), .vc_idle(vc_idle)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] exp_q [8][$];
  bit         tail_q [8][$];
  int  tails [8];
  int  first_cyc [8];
  bit  seen_first [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard as each VC hands out a flit
  always @(negedge clk) begin
    for (int v = 0; v < 8; v++) begin
      if (out_valid[v] && !seen_first[v]) begin
        seen_first[v] = 1'b1;
        first_cyc[v]  = cyc;
      end
      if (out_valid[v] && out_ready[v]) begin
        if (exp_q[v].size() == 0) begin
          chk(1'b0, $sformatf("R5 unexpected flit on VC%0d", v), int'(out_data[v*8 +: 8]), 0);
        end else begin
          logic [7:0] e;
          bit t;
          e = exp_q[v].pop_front();
          t = tail_q[v].pop_front();
          chk(out_data[v*8 +: 8] == e, $sformatf("R2/R5 flit on VC%0d", v),
              int'(out_data[v*8 +: 8]), int'(e));
          if (t) tails[v]++;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic send_pkt(input int src, input logic [7:0] hdr, input int vc,
                          input int nbody, input logic [7:0] base);
    logic [7:0] fl[$];
    fl.push_back(hdr);
    for (int k = 0; k < nbody; k++) fl.push_back((base + 8'(k)) & 8'h7F);
    fl.push_back(8'hFF);
    foreach (fl[k]) begin
      exp_q[vc].push_back(fl[k]);
      tail_q[vc].push_back(k == fl.size() - 1);
    end
    foreach (fl[k]) begin
      @(negedge clk);
      drv_v[src] = 1'b0;
      while (!in_ready[src]) @(negedge clk);
      drv_v[src] = 1'b1;
      drv_d[src] = fl[k];
    end
    @(negedge clk);
    drv_v[src] = 1'b0;
  endtask

  task automatic wait_tails(input int v, input int n);
    while (tails[v] < n) tick();
  endtask

  task automatic ack_vc(input int v);
    chk(vc_idle[v] == 1'b0, $sformatf("R4 VC%0d held until ack", v), int'(vc_idle[v]), 0);
    vc_ack[v] = 1'b1;
    tick();
    vc_ack[v] = 1'b0;
    chk(vc_idle[v] == 1'b1, $sformatf("R4 VC%0d free after ack", v), int'(vc_idle[v]), 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk(in_ready == 4'hF, "R1 in_ready", int'(in_ready), 'hF);
    chk(out_valid == 8'h00, "R1 out_valid", int'(out_valid), 0);
    chk(vc_idle == 8'hFF, "R1 vc_idle", int'(vc_idle), 'hFF);
  endtask

  task automatic run_all();
    // T1: reset
    do_reset();

    // T2: single packet to port 2, parked by backpressure (R2 R3 R4 R8)
    out_ready[4] = 1'b0;
    send_pkt(0, 8'h42, 4, 3, 8'h11);
    repeat (5) tick();
    chk(out_valid[4] == 1'b1, "R8 parked VC valid", int'(out_valid[4]), 1);
    chk(out_data[39:32] == 8'h42, "R8 parked head flit", int'(out_data[39:32]), 'h42);
    chk(vc_idle[4] == 1'b0, "R3 VC4 taken", int'(vc_idle[4]), 0);
    vc_ack[4] = 1'b1;
    tick();
    vc_ack[4] = 1'b0;
    tick();
    chk(vc_idle[4] == 1'b0, "R4 early ack ignored", int'(vc_idle[4]), 0);
    chk(out_data[39:32] == 8'h42, "R8 head flit unchanged", int'(out_data[39:32]), 'h42);
    out_ready[4] = 1'b1;
    wait_tails(4, 1);
    ack_vc(4);

    // T3: two inputs contend for port 1 (R3 R5 R7)
    fork
      send_pkt(1, 8'h01, 2, 1, 8'h20);
      send_pkt(3, 8'h81, 3, 5, 8'h30);
    join
    wait_tails(2, 1);
    wait_tails(3, 1);
    ack_vc(2);
    ack_vc(3);

    // T4: port 3 fully occupied, third packet stalls, other port flows (R6)
    out_ready[6] = 1'b0;
    out_ready[7] = 1'b0;
    send_pkt(0, 8'h03, 6, 2, 8'h40);
    send_pkt(1, 8'h13, 7, 2, 8'h50);
    fork
      send_pkt(2, 8'h23, 6, 2, 8'h60);
    join_none
    send_pkt(3, 8'h00, 0, 4, 8'h70);
    wait_tails(0, 1);
    chk(tails[0] == 1, "R6 other port delivered", tails[0], 1);
    chk(in_ready[2] == 1'b0, "R6 stalled input backpressured", int'(in_ready[2]), 0);
    chk(out_data[55:48] == 8'h03, "R6 VC6 still holds first packet", int'(out_data[55:48]), 'h03);
    chk(vc_idle[7:6] == 2'b00, "R6 both port-3 VCs taken", int'(vc_idle[7:6]), 0);
    ack_vc(0);
    out_ready[6] = 1'b1;
    wait_tails(6, 1);
    ack_vc(6);
    wait_tails(6, 2);
    ack_vc(6);
    out_ready[7] = 1'b1;
    wait_tails(7, 1);
    ack_vc(7);

    // T5: reset, then four inputs to four ports at once (R1 R7)
    do_reset();
    for (int v = 0; v < 8; v++) begin
      seen_first[v] = 1'b0;
      tails[v] = 0;
    end
    fork
      send_pkt(0, 8'h01, 2, 2, 8'h01);
      send_pkt(1, 8'h02, 4, 2, 8'h05);
      send_pkt(2, 8'h03, 6, 2, 8'h09);
      send_pkt(3, 8'h00, 0, 2, 8'h0D);
    join
    wait_tails(2, 1);
    wait_tails(4, 1);
    wait_tails(6, 1);
    wait_tails(0, 1);
    chk(first_cyc[4] - first_cyc[2] == 1, "R7 input1 after input0", first_cyc[4] - first_cyc[2], 1);
    chk(first_cyc[6] - first_cyc[4] == 1, "R7 input2 after input1", first_cyc[6] - first_cyc[4], 1);
    chk(first_cyc[0] - first_cyc[6] == 1, "R7 input3 after input2", first_cyc[0] - first_cyc[6], 1);
    ack_vc(2);
    ack_vc(4);
    ack_vc(6);
    ack_vc(0);
    repeat (3) tick();
    for (int v = 0; v < 8; v++)
      chk(exp_q[v].size() == 0, $sformatf("R2 VC%0d scoreboard drained", v), exp_q[v].size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      drv_v[i] = 1'b0;
      drv_d[i] = 8'h00;
    end
    for (int v = 0; v < 8; v++) begin
      tails[v] = 0;
      first_cyc[v] = 0;
      seen_first[v] = 1'b0;
    end
    out_ready = 8'hFF;
    vc_ack = 8'h00;
    rst_n = 1'b0;
    fork
      run_all();
      begin
        while (cyc < 150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule